// File: doc/BRIEF.md
# Clock Master Switch Controller

This block decides which of three oscillators supplies the master clock. The three sources are a fast internal RC, a slow internal RC and an external crystal. Software writes a one-byte source code into a target register. The block then asks the oscillator block to start that source and waits for the source's ready input. When switching is allowed, it moves the code into a status register. The status register is the select code sent to the glitch-free clock multiplexer, which lies outside this block.

The block has two modes. In manual mode, the interrupt flag only reports that the requested source has become ready, and the switch waits until software sets the switch enable bit. In automatic mode, the switch commits as soon as the source is ready, and the flag reports that the switch has completed. Software can abort a switch that is in progress. A safe-oscillator event, or a wakeup from halt with fast wakeup enabled, forces the target back to the fast internal RC. If the status register ever holds a code that is not legal, the block raises a reset request.

Top module: `clk_master_switch`

## Requirements
- R1: After reset, the status register (offset 3) and the target register (offset 4) read 0xE1. The control register (offset 5) reads 0x00, `switch_irq` is 0 and `osc_req` is 3'b001.
- R2: The source codes are 0xE1 for the fast internal RC (`osc_req`/`src_ready` bit 0), 0xD2 for the slow internal RC (bit 1) and 0xB4 for the crystal (bit 2). A write to offset 4 with a legal code that differs from the status stores the code and sets busy (control bit 0). Any other value leaves the target unchanged. 0xD2 is legal only while `lsi_ok` is 1.
- R3: A write to offset 4 while busy is 1 leaves the target unchanged.
- R4: `osc_req` has the status source's bit set at all times. While busy is 1, it also has the target source's bit set.
- R5: In manual mode (control bit 1 = 0), the flag (control bit 3) becomes 1 one edge after busy is 1 and the target's `src_ready` bit is 1. The status register does not change.
- R6: In automatic mode (control bit 1 = 1), once busy is 1 and the target is ready, the next edge copies the target into the status register, clears busy and sets the flag.
- R7: A write to offset 5 with bit 0 = 0 while busy is 1 clears busy and returns the target to the status code. If the target becomes ready in the same cycle, the abort still wins and no commit happens.
- R8: Writing 0 to control bit 3 clears the flag and writing 1 to it has no effect. If the hardware sets the flag in the same cycle, the flag stays 1.
- R9: `switch_irq` equals the flag ANDed with the interrupt enable (control bit 2).
- R10: When `safe_aux` is 1, or when `halt_wake` and `fast_wake_en` are both 1, the target becomes 0xE1 and busy becomes (status != 0xE1). This takes priority over any register write in the same cycle. `halt_wake` has no effect while `fast_wake_en` is 0.
- R11: `reset_req` is 1 exactly when the status register does not hold one of the three legal codes. The status register is loaded only from a validated target, so `reset_req` stays 0 in normal operation.
- R12: Offset 5 reads 0 in bits 7:4. Offsets other than 3, 4 and 5 read 0x00. `clk_sel` equals the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| lsi_ok | input | 1 | Option that allows the slow internal RC code |
| src_ready | input | 3 | Per-source ready inputs from the oscillator block |
| safe_aux | input | 1 | Safe-oscillator event: forces the target to 0xE1 |
| halt_wake | input | 1 | Wakeup-from-halt pulse |
| fast_wake_en | input | 1 | Fast wakeup enable |
| osc_req | output | 3 | Per-source oscillator enable requests |
| clk_sel | output | 8 | Select code to the clock multiplexer |
| switch_irq | output | 1 | Switch interrupt |
| reset_req | output | 1 | Reset request for an illegal status code |

## Verification
Two pairs of functions can fall into the same edge, and the bench provokes each pair on purpose. The first pair is a software flag clear and a hardware flag set. The bench holds the target ready in manual mode and writes 0 to bit 3; the flag must read 1 afterwards. The second pair is an abort and a commit. In automatic mode, the bench raises the target's ready input on the same edge as an abort write; the status must keep its old code and busy must read 0. A third collision applies a safe-oscillator event together with a target write, and the target must read 0xE1. Separately, all 256 target values are swept with the slow-RC option both off and on.

// File: rtl/cms_pkg.sv
// Package: shared codes, offsets and widths for the clock master switch.
// Assumes exactly three sources, ordered fast RC, slow RC, crystal.
package cms_pkg;
    localparam int CODE_W = 8;
    localparam int ADDR_W = 3;
    localparam int NSRC   = 3;

    localparam logic [CODE_W-1:0] CODE_HSI = 8'hE1;
    localparam logic [CODE_W-1:0] CODE_LSI = 8'hD2;
    localparam logic [CODE_W-1:0] CODE_HSE = 8'hB4;

    localparam logic [CODE_W-1:0] SRC_CODE [NSRC] = '{CODE_HSI, CODE_LSI, CODE_HSE};

    localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_TARGET = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd5;

    localparam int BIT_BUSY = 0;
    localparam int BIT_SWEN = 1;
    localparam int BIT_IEN  = 2;
    localparam int BIT_FLAG = 3;
endpackage

// File: rtl/cms_code_check.sv
// Module: cms_code_check
// Decides whether a source code is legal. The slow-RC code counts as legal
// only while allow_lsi is high. Purely combinational.
module cms_code_check
    import cms_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic              allow_lsi,
    output logic              legal
);
    // Compare the code against each source code; mask the slow RC by its option.
    always_comb begin
        legal = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (code == SRC_CODE[i] && (SRC_CODE[i] != CODE_LSI || allow_lsi))
                legal = 1'b1;
        end
    end
endmodule

// File: rtl/cms_switch_core.sv
// Module: cms_switch_core
// Holds the status, target and busy state of the master-clock switch.
// Priority, highest first: forced return to the fast RC, software abort,
// commit, accepted target write. Assumes code_ok has been checked by the caller.
module cms_switch_core
    import cms_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_wr,
    input  logic [CODE_W-1:0] wdata,
    input  logic              code_ok,
    input  logic              abort_req,
    input  logic              swen,
    input  logic [NSRC-1:0]   src_ready,
    input  logic              force_hsi,
    output logic [CODE_W-1:0] status,
    output logic [CODE_W-1:0] target,
    output logic              busy,
    output logic              flag_set
);
    logic [NSRC-1:0] tgt_hit;
    logic            tgt_rdy;
    logic            abort;
    logic            commit;
    logic            accept;

    // One match line for each source: is this source the target?
    for (genvar i = 0; i < NSRC; i++) begin : g_hit
        assign tgt_hit[i] = (target == SRC_CODE[i]);
    end

    // Decode the events of the current cycle.
    always_comb begin
        tgt_rdy  = busy && |(tgt_hit & src_ready);
        abort    = abort_req && busy;
        commit   = tgt_rdy && swen && !abort && !force_hsi;
        accept   = tgt_wr && !busy && code_ok && (wdata != status);
        flag_set = commit || (tgt_rdy && !swen && !abort && !force_hsi);
    end

    // Update the state by priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= CODE_HSI;
            target <= CODE_HSI;
            busy   <= 1'b0;
        end else if (force_hsi) begin
            target <= CODE_HSI;
            busy   <= (status != CODE_HSI);
        end else if (abort) begin
            target <= status;
            busy   <= 1'b0;
        end else if (commit) begin
            status <= target;
            busy   <= 1'b0;
        end else if (accept) begin
            target <= wdata;
            busy   <= 1'b1;
        end
    end
endmodule

// File: rtl/cms_ctrl_regs.sv
// Module: cms_ctrl_regs
// Holds the software control bits (interrupt enable, switch enable) and the
// interrupt flag. A hardware set of the flag wins over a software clear.
module cms_ctrl_regs
    import cms_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CODE_W-1:0] wdata,
    input  logic              flag_set,
    output logic              flag,
    output logic              ien,
    output logic              swen
);
    // Load the enables from a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien  <= 1'b0;
            swen <= 1'b0;
        end else if (ctl_wr) begin
            ien  <= wdata[BIT_IEN];
            swen <= wdata[BIT_SWEN];
        end
    end

    // Set the flag from hardware; clear it when software writes a zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (flag_set)
            flag <= 1'b1;
        else if (ctl_wr && !wdata[BIT_FLAG])
            flag <= 1'b0;
    end
endmodule

// File: rtl/clk_master_switch.sv
// Module: clk_master_switch (top)
// Decodes register writes, forms the forced return to the fast RC, drives the
// oscillator requests, the readback, the interrupt and the reset request.
// Assumes that a single write strobe and the combinational readback are enough.
module clk_master_switch
    import cms_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CODE_W-1:0] reg_wdata,
    output logic [CODE_W-1:0] reg_rdata,
    input  logic              lsi_ok,
    input  logic [NSRC-1:0]   src_ready,
    input  logic              safe_aux,
    input  logic              halt_wake,
    input  logic              fast_wake_en,
    output logic [NSRC-1:0]   osc_req,
    output logic [CODE_W-1:0] clk_sel,
    output logic              switch_irq,
    output logic              reset_req
);
    logic              tgt_wr;
    logic              ctl_wr;
    logic              force_hsi;
    logic              wr_legal;
    logic              st_legal;
    logic [CODE_W-1:0] sw_status;
    logic [CODE_W-1:0] sw_target;
    logic              sw_busy;
    logic              flag_set;
    logic              ctl_flag;
    logic              ctl_ien;
    logic              ctl_swen;

    // Decode the write strobes and the forced return to the fast RC.
    always_comb begin
        tgt_wr    = reg_we && (reg_addr == OFS_TARGET);
        ctl_wr    = reg_we && (reg_addr == OFS_CTRL);
        force_hsi = safe_aux || (halt_wake && fast_wake_en);
    end

    cms_code_check u_wr_check (
        .code      (reg_wdata),
        .allow_lsi (lsi_ok),
        .legal     (wr_legal)
    );

    cms_code_check u_st_check (
        .code      (sw_status),
        .allow_lsi (1'b1),
        .legal     (st_legal)
    );

    cms_switch_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tgt_wr    (tgt_wr),
        .wdata     (reg_wdata),
        .code_ok   (wr_legal),
        .abort_req (ctl_wr && !reg_wdata[BIT_BUSY]),
        .swen      (ctl_swen),
        .src_ready (src_ready),
        .force_hsi (force_hsi),
        .status    (sw_status),
        .target    (sw_target),
        .busy      (sw_busy),
        .flag_set  (flag_set)
    );

    cms_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .wdata    (reg_wdata),
        .flag_set (flag_set),
        .flag     (ctl_flag),
        .ien      (ctl_ien),
        .swen     (ctl_swen)
    );

    // One request line for each source: the running source, plus the target during a switch.
    for (genvar i = 0; i < NSRC; i++) begin : g_req
        assign osc_req[i] = (sw_status == SRC_CODE[i]) ||
                            (sw_busy && (sw_target == SRC_CODE[i]));
    end

    // Readback mux for the three registers.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STATUS: reg_rdata = sw_status;
            OFS_TARGET: reg_rdata = sw_target;
            OFS_CTRL: begin
                reg_rdata[BIT_FLAG] = ctl_flag;
                reg_rdata[BIT_IEN]  = ctl_ien;
                reg_rdata[BIT_SWEN] = ctl_swen;
                reg_rdata[BIT_BUSY] = sw_busy;
            end
            default: reg_rdata = '0;
        endcase
    end

    // Outputs to the clock multiplexer, the interrupt controller and the reset logic.
    always_comb begin
        clk_sel    = sw_status;
        switch_irq = ctl_flag && ctl_ien;
        reset_req  = !st_legal;
    end
endmodule

// File: rtl/cms_checker.sv
// Module: cms_checker
// Temporal checks for clk_master_switch. It is bound to the top and only
// observes signals.
module cms_checker
    import cms_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              safe_aux,
    input logic              halt_wake,
    input logic              fast_wake_en,
    input logic              busy,
    input logic [CODE_W-1:0] target,
    input logic [CODE_W-1:0] status,
    input logic              flag,
    input logic [NSRC-1:0]   osc_req,
    input logic              reset_req
);
    assert_protect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && reg_addr == OFS_TARGET && !safe_aux && !(halt_wake && fast_wake_en))
        |=> $stable(target));

    assert_req_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(osc_req) >= 1) && ($countones(osc_req) <= 2));

    assert_flag_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(busy));

    assert_status_needs_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status) |-> $past(busy));

    assert_idle_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (target == status));

    assert_force_hsi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        safe_aux |=> (target == CODE_HSI));

    assert_no_reset_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reset_req);
endmodule

bind clk_master_switch cms_checker u_cms_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .safe_aux     (safe_aux),
    .halt_wake    (halt_wake),
    .fast_wake_en (fast_wake_en),
    .busy         (sw_busy),
    .target       (sw_target),
    .status       (sw_status),
    .flag         (ctl_flag),
    .osc_req      (osc_req),
    .reset_req    (reset_req)
);

// File: tb/clk_master_switch_bench.sv
// Bench for clk_master_switch. Inputs change on the falling edge and outputs
// are sampled after that edge.
module clk_master_switch_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       lsi_ok = 1'b0;
    logic [2:0] src_ready = 3'b000;
    logic       safe_aux = 1'b0;
    logic       halt_wake = 1'b0;
    logic       fast_wake_en = 1'b0;
    logic [2:0] osc_req;
    logic [7:0] clk_sel;
    logic       switch_irq;
    logic       reset_req;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_master_switch u_clk_master_switch (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lsi_ok(lsi_ok),
        .src_ready(src_ready), .safe_aux(safe_aux), .halt_wake(halt_wake),
        .fast_wake_en(fast_wake_en), .osc_req(osc_req), .clk_sel(clk_sel),
        .switch_irq(switch_irq), .reset_req(reset_req)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: values after reset
        rd_check("R1 status", 3'd3, 8'hE1);
        rd_check("R1 target", 3'd4, 8'hE1);
        rd_check("R1 ctrl", 3'd5, 8'h00);
        check("R1 irq", {7'd0, switch_irq}, 8'h00);
        check("R1 osc_req", {5'd0, osc_req}, 8'h01);
        check("R11 reset_req", {7'd0, reset_req}, 8'h00);

        // R2: sweep every target value, with the slow-RC option off and on
        for (int allow = 0; allow < 2; allow++) begin
            lsi_ok = allow[0];
            for (int v = 0; v < 256; v++) begin
                logic expb;
                expb = (v == 8'hB4) || (v == 8'hD2 && allow == 1);
                wr(3'd4, v[7:0]);
                rd_check("R2 sweep target", 3'd4, expb ? v[7:0] : 8'hE1);
                rd_check("R2 sweep busy", 3'd5, {7'd0, expb});
                if (expb) begin
                    check("R4 sweep osc_req", {5'd0, osc_req},
                          8'h01 | (v == 8'hB4 ? 8'h04 : 8'h02));
                    wr(3'd5, 8'h00);
                    rd_check("R7 sweep abort target", 3'd4, 8'hE1);
                end
            end
        end
        lsi_ok = 1'b0;

        // R5: manual mode, the target becomes ready
        wr(3'd4, 8'hB4);
        check("R4 osc_req busy", {5'd0, osc_req}, 8'h05);
        @(negedge clk); src_ready = 3'b101;
        @(negedge clk);
        rd_check("R5 flag set manual", 3'd5, 8'h09);
        rd_check("R5 status kept", 3'd3, 8'hE1);
        check("R9 irq disabled", {7'd0, switch_irq}, 8'h00);
        wr(3'd5, 8'h0D);
        check("R9 irq enabled", {7'd0, switch_irq}, 8'h01);
        // R8: software clear and hardware set in the same cycle
        wr(3'd5, 8'h05);
        rd_check("R8 set wins", 3'd5, 8'h0D);
        // R6: switch enable set, commit on the following edge
        wr(3'd5, 8'h0F);
        @(negedge clk); #1;
        rd_check("R6 status committed", 3'd3, 8'hB4);
        rd_check("R6 ctrl after commit", 3'd5, 8'h0E);
        check("R12 clk_sel", clk_sel, 8'hB4);
        check("R4 osc_req idle", {5'd0, osc_req}, 8'h04);

        // R8: plain flag clear
        wr(3'd5, 8'h06);
        rd_check("R8 flag cleared", 3'd5, 8'h06);
        check("R9 irq low", {7'd0, switch_irq}, 8'h00);

        // R3: a target write while busy is ignored
        src_ready = 3'b000;
        lsi_ok = 1'b1;
        wr(3'd4, 8'hE1);
        wr(3'd4, 8'hD2);
        rd_check("R3 protect", 3'd4, 8'hE1);
        lsi_ok = 1'b0;

        // R7: an abort and the target becoming ready in the same cycle
        @(negedge clk);
        src_ready = 3'b001; reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 8'h06;
        @(negedge clk);
        reg_we = 1'b0;
        rd_check("R7 abort wins status", 3'd3, 8'hB4);
        rd_check("R7 abort target", 3'd4, 8'hB4);
        rd_check("R7 abort ctrl", 3'd5, 8'h06);
        @(negedge clk);
        rd_check("R7 no late commit", 3'd3, 8'hB4);

        // R6: automatic mode with the target already ready
        wr(3'd4, 8'hE1);
        rd_check("R6 busy before commit", 3'd5, 8'h07);
        @(negedge clk);
        rd_check("R6 auto status", 3'd3, 8'hE1);
        rd_check("R6 auto ctrl", 3'd5, 8'h0E);
        check("R9 irq auto", {7'd0, switch_irq}, 8'h01);

        // R10: halt wakeup with fast wakeup off, then a safe-oscillator event
        wr(3'd5, 8'h06);
        src_ready = 3'b000;
        wr(3'd4, 8'hB4);
        @(negedge clk); halt_wake = 1'b1;
        @(negedge clk); halt_wake = 1'b0;
        rd_check("R10 wake ignored", 3'd4, 8'hB4);
        @(negedge clk); safe_aux = 1'b1;
        @(negedge clk); safe_aux = 1'b0;
        rd_check("R10 aux target", 3'd4, 8'hE1);
        rd_check("R10 aux busy", 3'd5, 8'h06);

        // R10: fast wakeup while the status is the crystal
        src_ready = 3'b100;
        wr(3'd4, 8'hB4);
        @(negedge clk);
        rd_check("R6 to crystal", 3'd3, 8'hB4);
        src_ready = 3'b000;
        wr(3'd5, 8'h06);
        fast_wake_en = 1'b1;
        @(negedge clk); halt_wake = 1'b1;
        @(negedge clk); halt_wake = 1'b0;
        rd_check("R10 wake target", 3'd4, 8'hE1);
        rd_check("R10 wake busy", 3'd5, 8'h07);
        src_ready = 3'b001;
        @(negedge clk);
        rd_check("R10 wake commit", 3'd3, 8'hE1);
        fast_wake_en = 1'b0;

        // R10: the forced return beats a target write in the same cycle
        src_ready = 3'b000;
        @(negedge clk);
        safe_aux = 1'b1; reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'hB4;
        @(negedge clk);
        safe_aux = 1'b0; reg_we = 1'b0;
        rd_check("R10 priority target", 3'd4, 8'hE1);
        rd_check("R10 priority busy", 3'd5, 8'h0E);

        // R12: unused offsets read zero
        rd_check("R12 ofs0", 3'd0, 8'h00);
        rd_check("R12 ofs1", 3'd1, 8'h00);
        rd_check("R12 ofs2", 3'd2, 8'h00);
        rd_check("R12 ofs6", 3'd6, 8'h00);
        rd_check("R12 ofs7", 3'd7, 8'h00);
        check("R11 reset_req end", {7'd0, reset_req}, 8'h00);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule